// File: doc/BRIEF.md
# Transition-Count Response Compactor

This block reduces the response of a circuit under test to one number during a self-test session. Each cycle that a response vector is marked valid, every output bit is compared with the same bit of the previously accepted vector, and each bit that changed, whether it rose or fell, adds one to a running signature. Summing over all outputs and over the whole session gives a single count. Because only the number of changes is kept, distinct responses can collapse to the same count (aliasing).

A test controller pulses the clear strobe to open a session, streams response vectors with a valid strobe, and marks the final vector with a last strobe. On the cycle after the final vector the block raises its done flag and compares the signature with a precomputed good-machine count supplied on an input. From then until the next clear it shows either pass or fail. The count register is sized for `OUT_W` outputs over up to `MAX_VEC` vectors and holds at its maximum value instead of wrapping.

Top module: `toggle_sig_compactor`

## Requirements
- R1: During and after reset, before any vector, sigCount is 0 and sessionDone, passFlag and failFlag are 0.
- R2: One cycle after clearStb is sampled high, sigCount is 0, sessionDone is 0 and the next accepted vector is treated as the first. A vector presented in the same cycle as clearStb is dropped.
- R3: The first vector accepted after reset or a clear only records the previous-value register and leaves sigCount unchanged.
- R4: Each later accepted vector adds to sigCount the number of bit positions in which it differs from the previous accepted vector (0→1 and 1→0 count alike). The new value shows after the clock edge that samples it. Cycles with vecValid low change neither sigCount nor the previous-value register.
- R5: sigCount is CNT_W = clog2(OUT_W·MAX_VEC)+1 bits wide and saturates at all ones (16383 with the default parameters) instead of wrapping.
- R6: A vector accepted with vecLast high is included in sigCount, and sessionDone is high from the cycle after it is sampled.
- R7: While sessionDone is high, passFlag is 1 exactly when sigCount equals expCount, and failFlag is its complement. The compare follows expCount with no added delay. While sessionDone is low both flags are 0.
- R8: While sessionDone is high, valid vectors are ignored until the next clear, and sigCount holds.
- R9: Only the count is checked. A faulty stream with the same total number of changes passes (aliasing), while flipping one bit of the final vector always shifts the count by one and fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| clearStb | input | 1 | Starts a new session; clears the count and the done state |
| vecValid | input | 1 | respVec carries a response vector this cycle |
| vecLast | input | 1 | With vecValid: this vector is the final one of the session |
| respVec | input | OUT_W | Response vector from the circuit under test |
| expCount | input | CNT_W | Good-machine transition count |
| sigCount | output | CNT_W | Accumulated transition count |
| sessionDone | output | 1 | Final vector has been accumulated |
| passFlag | output | 1 | Done and count matches expCount |
| failFlag | output | 1 | Done and count differs from expCount |

## Verification
Every result is due one clock edge after the stimulus that causes it. sigCount and sessionDone change on the edge that samples a valid vector or a clear. passFlag and failFlag follow expCount in the same cycle once done is set. The bench drives inputs on the falling edge and reads outputs at the next falling edge, half a cycle after the sampling edge, so each check sees exactly one edge's worth of effect. Random sessions with idle gaps, bit-flip fault injection, the clear-versus-valid collision and a long saturating stream are compared against a bench model of the count.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef struct packed {
    logic clrAcc;
    logic loadPrev;
    logic addDelta;
  } tsc_strobe_t;
endpackage

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clearStb,
  input  logic        vecValid,
  input  logic        vecLast,
  output tsc_strobe_t strobes,
  output logic        doneQ
);
  logic primedQ;
  logic accept;

  assign accept = !clearStb && vecValid && !doneQ;

  always_comb begin
    strobes.clrAcc   = clearStb;
    strobes.loadPrev = accept;
    strobes.addDelta = accept && primedQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primedQ <= 1'b0;
      doneQ   <= 1'b0;
    end else if (clearStb) begin
      primedQ <= 1'b0;
      doneQ   <= 1'b0;
    end else if (accept) begin
      primedQ <= 1'b1;
      if (vecLast) doneQ <= 1'b1;
    end
  end
endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
#(
  parameter int OUT_W = 8,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  tsc_strobe_t      strobes,
  input  logic [OUT_W-1:0] respVec,
  input  logic [CNT_W-1:0] expCount,
  output logic [CNT_W-1:0] accQ,
  output logic             matchExp
);
  localparam int DELTA_W = $clog2(OUT_W + 1);

  logic [OUT_W-1:0]   prevQ;
  logic [OUT_W-1:0]   diffBits;
  logic [DELTA_W-1:0] delta;
  logic [CNT_W:0]     sumWide;
  logic [CNT_W-1:0]   sumSat;

  assign diffBits = respVec ^ prevQ;

  always_comb begin
    delta = '0;
    for (int i = 0; i < OUT_W; i++) begin
      delta = delta + DELTA_W'(diffBits[i]);
    end
  end

  assign sumWide  = {1'b0, accQ} + (CNT_W + 1)'(delta);
  assign sumSat   = sumWide[CNT_W] ? {CNT_W{1'b1}} : sumWide[CNT_W-1:0];
  assign matchExp = (accQ == expCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= '0;
      accQ  <= '0;
    end else if (strobes.clrAcc) begin
      accQ  <= '0;
    end else begin
      if (strobes.loadPrev) prevQ <= respVec;
      if (strobes.addDelta) accQ  <= sumSat;
    end
  end
endmodule

// File: rtl/toggle_sig_compactor.sv
module toggle_sig_compactor
  import tsc_pkg::*;
#(
  parameter int OUT_W   = 8,
  parameter int MAX_VEC = 1024,
  localparam int CNT_W  = $clog2(OUT_W * MAX_VEC) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearStb,
  input  logic             vecValid,
  input  logic             vecLast,
  input  logic [OUT_W-1:0] respVec,
  input  logic [CNT_W-1:0] expCount,
  output logic [CNT_W-1:0] sigCount,
  output logic             sessionDone,
  output logic             passFlag,
  output logic             failFlag
);
  tsc_strobe_t strobes;
  logic        matchExp;

  tsc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clearStb (clearStb),
    .vecValid (vecValid),
    .vecLast  (vecLast),
    .strobes  (strobes),
    .doneQ    (sessionDone)
  );

  tsc_datapath #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .respVec  (respVec),
    .expCount (expCount),
    .accQ     (sigCount),
    .matchExp (matchExp)
  );

  assign passFlag = sessionDone && matchExp;
  assign failFlag = sessionDone && !matchExp;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int OUT_W = 8,
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             clearStb,
  input logic             vecValid,
  input logic             vecLast,
  input logic [CNT_W-1:0] expCount,
  input logic [CNT_W-1:0] sigCount,
  input logic             sessionDone,
  input logic             passFlag,
  input logic             failFlag
);
  logic started;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  // R1
  always_comb begin
    if (!rstN) begin
      reset_state_chk: assert (sigCount == '0 && !sessionDone);
    end
  end

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearStb |=> (sigCount == '0 && !sessionDone));

  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (started && !$past(clearStb)) |->
      (({1'b0, sigCount} - {1'b0, $past(sigCount)}) <= (CNT_W + 1)'(OUT_W)));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (started && !$past(clearStb)) |-> (sigCount >= $past(sigCount)));

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && vecLast && !clearStb && !sessionDone) |=> sessionDone);

  // R7
  verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    sessionDone ? (passFlag == (sigCount == expCount) && failFlag == !passFlag)
                : (!passFlag && !failFlag));

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sessionDone && !clearStb) |=> ($stable(sigCount) && sessionDone));
endmodule

bind toggle_sig_compactor tsc_checker #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .clearStb    (clearStb),
  .vecValid    (vecValid),
  .vecLast     (vecLast),
  .expCount    (expCount),
  .sigCount    (sigCount),
  .sessionDone (sessionDone),
  .passFlag    (passFlag),
  .failFlag    (failFlag)
);

// File: tb/tb_toggle_sig_compactor.sv
`timescale 1ns/1ps
module tb_toggle_sig_compactor;
  localparam int OUT_W   = 8;
  localparam int MAX_VEC = 1024;
  localparam int CNT_W   = $clog2(OUT_W * MAX_VEC) + 1;
  localparam int SAT     = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             clearStb = 1'b0;
  logic             vecValid = 1'b0;
  logic             vecLast = 1'b0;
  logic [OUT_W-1:0] respVec = '0;
  logic [CNT_W-1:0] expCount = '0;
  logic [CNT_W-1:0] sigCount;
  logic             sessionDone, passFlag, failFlag;

  int errors = 0;
  int checks = 0;

  int               refCount;
  logic [OUT_W-1:0] refPrev;
  bit               refPrimed;
  bit               refDone;
  logic [OUT_W-1:0] stream [64];

  always #2.5 clk = ~clk;

  toggle_sig_compactor #(.OUT_W(OUT_W), .MAX_VEC(MAX_VEC)) dut (
    .clk(clk), .rstN(rstN), .clearStb(clearStb), .vecValid(vecValid),
    .vecLast(vecLast), .respVec(respVec), .expCount(expCount),
    .sigCount(sigCount), .sessionDone(sessionDone),
    .passFlag(passFlag), .failFlag(failFlag)
  );

  function automatic int popc(logic [OUT_W-1:0] v);
    int n = 0;
    for (int i = 0; i < OUT_W; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkCount(string tag);
    check(int'(sigCount) == refCount, tag, int'(sigCount), refCount);
  endtask

  task automatic modelReset();
    refCount = 0; refPrimed = 0; refDone = 0; refPrev = '0;
  endtask

  task automatic sendVec(logic [OUT_W-1:0] v, bit last);
    @(negedge clk);
    clearStb = 1'b0; vecValid = 1'b1; respVec = v; vecLast = last;
    if (!refDone) begin
      if (refPrimed) begin
        refCount += popc(v ^ refPrev);
        if (refCount > SAT) refCount = SAT;
      end
      refPrev = v; refPrimed = 1;
      if (last) refDone = 1;
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      vecValid = 1'b0; vecLast = 1'b0; clearStb = 1'b0;
      respVec = OUT_W'($urandom);
    end
  endtask

  task automatic doClear();
    @(negedge clk);
    clearStb = 1'b1; vecValid = 1'b0; vecLast = 1'b0;
    @(negedge clk);
    clearStb = 1'b0;
    modelReset();
  endtask

  task automatic verdict(int good, string tag);
    expCount = CNT_W'(good);
    #0.1;
    check(passFlag == (refCount == good) && failFlag == (refCount != good),
          tag, int'(passFlag), int'(refCount == good));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    modelReset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sigCount == '0 && !sessionDone && !passFlag && !failFlag,
          "R1 reset", int'(sigCount), 0);
    rstN = 1'b1;
    idle(2);
    check(sigCount == '0 && !sessionDone, "R1 after reset", int'(sigCount), 0);

    // R3 first vector loads only
    doClear();
    sendVec(8'h00, 0); idle(1);
    checkCount("R3 first vector");
    // R4 both directions
    sendVec(8'hFF, 0); idle(1);
    checkCount("R4 rising x8");
    sendVec(8'h0F, 0); idle(3);
    checkCount("R4 falling x4 and idle gap");
    sendVec(8'h0F, 1); idle(1);
    checkCount("R6 last included");
    check(sessionDone == 1'b1, "R6 done", int'(sessionDone), 1);
    verdict(12, "R7 pass on match");
    verdict(13, "R7 fail on mismatch");
    // R8 ignored after done
    sendVec(8'hF0, 0); idle(1);
    check(int'(sigCount) == 12 && sessionDone, "R8 frozen", int'(sigCount), 12);

    // R2 clear wins over a same-cycle vector
    @(negedge clk);
    clearStb = 1'b1; vecValid = 1'b1; respVec = 8'hFF;
    @(negedge clk);
    clearStb = 1'b0; vecValid = 1'b0;
    modelReset();
    check(sigCount == '0 && !sessionDone && !passFlag && !failFlag,
          "R2 clear", int'(sigCount), 0);
    sendVec(8'h00, 0); idle(1);
    checkCount("R2 colliding vector dropped");
    sendVec(8'h01, 0); idle(1);
    checkCount("R4 single toggle");
    doClear();
    check(sigCount == '0 && !sessionDone, "R2 mid-session clear", int'(sigCount), 0);

    // R9 aliasing: bit0 0,0,1 and 0,1,1 both give one transition
    sendVec(8'h00, 0); sendVec(8'h00, 0); sendVec(8'h01, 1); idle(1);
    verdict(1, "R9 good stream");
    doClear();
    sendVec(8'h00, 0); sendVec(8'h01, 0); sendVec(8'h01, 1); idle(1);
    check(passFlag == 1'b1, "R9 aliased fault passes", int'(passFlag), 1);
    doClear();
    sendVec(8'h00, 0); sendVec(8'h00, 0); sendVec(8'h03, 1); idle(1);
    check(failFlag == 1'b1, "R9 last-bit flip fails", int'(failFlag), 1);

    // Random sessions with gaps and fault injection
    for (int s = 0; s < 8; s++) begin
      int len = 2 + int'($urandom_range(62));
      int good;
      int flipBit;
      for (int k = 0; k < len; k++) stream[k] = OUT_W'($urandom);
      doClear();
      for (int k = 0; k < len; k++) begin
        sendVec(stream[k], k == len - 1);
        if ($urandom_range(3) == 0) idle(1 + int'($urandom_range(2)));
      end
      idle(1);
      checkCount("R4 random session count");
      check(sessionDone == 1'b1, "R6 random done", int'(sessionDone), 1);
      good = refCount;
      verdict(good, "R7 random pass");
      flipBit = int'($urandom_range(OUT_W - 1));
      stream[len-1][flipBit] = ~stream[len-1][flipBit];
      doClear();
      for (int k = 0; k < len; k++) sendVec(stream[k], k == len - 1);
      idle(1);
      checkCount("R4 injected session count");
      check(failFlag == 1'b1 && !passFlag, "R9 injected flip fails",
            int'(failFlag), 1);
    end

    // R5 saturation
    doClear();
    for (int k = 0; k < 2100; k++) sendVec((k % 2) ? 8'hFF : 8'h00, k == 2099);
    idle(1);
    check(int'(sigCount) == SAT, "R5 saturation", int'(sigCount), SAT);
    verdict(SAT, "R5 saturated verdict");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule